// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Bank

This block is the write-only control register bank for a single 16-bit digital-to-analog channel. It takes already-decoded register writes on a parallel port (a 4-bit address, 16-bit data and a one-cycle write enable). It holds two copies of the converter code. The first is a staging buffer that every data write fills. The second is the active code that drives the converter.

A two-state mode machine chooses how the active code follows the buffer. In state MODE_DIRECT, a data write passes straight to the active code. In state MODE_BUFFERED, a data write only fills the buffer, and the active code takes the buffered value when a load arrives. A load comes either from a self-clearing command bit or from a falling edge on an active-low load pin. The transition MODE_DIRECT to MODE_BUFFERED is taken when the mode register is written with bit 0 set. The transition MODE_BUFFERED to MODE_DIRECT is taken when that bit is written clear. The transition from any state back to MODE_DIRECT is taken on a hardware reset or a keyed soft reset.

The reset value of both code copies is chosen by a strap pin: zero, or mid-scale. A one-cycle strobe marks every clock on which the active code is loaded, so a downstream serializer knows when to send a new sample.

Top module: `dac_dbuf_regs`

## Requirements
- R1: While `rst_n` is low (synchronous, active-low), the buffer and the active code are set to 0000h when `rst_code_sel_i` is 0 and to 8000h when it is 1. The mode becomes MODE_DIRECT and `dac_update_o` is 0.
- R2: In MODE_DIRECT, a write to address 8h puts the data on `dac_code_o` at the clock edge that samples the write, and `dac_update_o` is 1 for the following cycle.
- R3: A write to address 2h sets the mode from data bit 0 (1 = MODE_BUFFERED, 0 = MODE_DIRECT); data bits 15:1 are ignored. In MODE_BUFFERED, a write to address 8h changes only the buffer: `dac_code_o` holds and no strobe is issued.
- R4: A write to address 5h with data bit 4 set copies the buffer to `dac_code_o`, with a strobe, only in MODE_BUFFERED. In MODE_DIRECT it has no effect. Bits 15:5 of that register are ignored, and the load bit holds no state.
- R5: In MODE_BUFFERED, a high-to-low transition on `load_n_i` loads the buffer into the active code on the third rising edge after the pin falls. One load is made per transition, however long the pin stays low. In MODE_DIRECT, the pin is ignored.
- R6: A write to address 5h with bits 3:0 equal to 1010b is a soft reset. It applies the R1 defaults (mode and both codes, from the current `rst_code_sel_i`) at the edge that samples the write and pulses `dac_update_o`. Any other value in bits 3:0 has no effect.
- R7: When one address-5h write carries both the reset key and bit 4, the soft reset wins and the load is discarded.
- R8: Writes to address 0h and to any address other than 0h, 2h, 5h and 8h change neither the buffer, the mode nor the active code.
- R9: `dac_update_o` is high for exactly the cycles that follow an edge on which the active code was loaded. The active code changes at most once per clock.
- R10: Data is 16-bit straight binary, MSB-aligned, passed through unmodified (for example 0001h, FFFFh, 8001h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_code_sel_i | input | 1 | Strap selecting the reset code: 0 gives 0000h, 1 gives 8000h |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Write data |
| load_n_i | input | 1 | Asynchronous active-low load pin |
| dac_code_o | output | 16 | Active converter code |
| dac_update_o | output | 1 | One-cycle pulse after each load of the active code |

## Verification
On every cycle, the assertions check the following. Any change of the active code is strobed. A direct-mode data write appears on the output one edge later. A buffered-mode data write alone leaves the output untouched. A soft reset lands on the strap-selected code in MODE_DIRECT. The synchronized pin edge never pulses twice in a row. Only the bench's scenarios can show the remaining behaviour. This covers that reserved bits and undefined addresses leave hidden buffer state intact (exposed later through a load). It also covers the exact three-edge latency of the pin, and that a combined reset-and-load write discards the load.

// File: rtl/dacrf_pkg.sv
package dacrf_pkg;
    localparam int DAC_W      = 16;
    localparam int ADDR_W     = 4;
    localparam int CTRL_W     = 5;

    localparam logic [ADDR_W-1:0] ADDR_NOOP = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_TRIG = 4'h5;
    localparam logic [ADDR_W-1:0] ADDR_CODE = 4'h8;

    localparam int MODE_BIT   = 0;
    localparam int LOAD_BIT   = 4;
    localparam int KEY_W      = 4;
    localparam logic [KEY_W-1:0] SRST_KEY = 4'b1010;

    typedef enum logic {
        MODE_DIRECT   = 1'b0,
        MODE_BUFFERED = 1'b1
    } mode_e;

    typedef struct packed {
        logic mode_wr;
        logic mode_val;
        logic load_sw;
        logic srst;
        logic code_wr;
    } wr_evt_t;
endpackage

// File: rtl/dacrf_decode.sv
module dacrf_decode
    import dacrf_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CTRL_W-1:0] ctrl_bits_i,
    output wr_evt_t           evt_o
);
    always_comb begin
        evt_o = '0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                ADDR_MODE: begin
                    evt_o.mode_wr  = 1'b1;
                    evt_o.mode_val = ctrl_bits_i[MODE_BIT];
                end
                ADDR_TRIG: begin
                    // Soft reset outranks the load command in the same word.
                    if (ctrl_bits_i[KEY_W-1:0] == SRST_KEY) begin
                        evt_o.srst = 1'b1;
                    end else begin
                        evt_o.load_sw = ctrl_bits_i[LOAD_BIT];
                    end
                end
                ADDR_CODE: evt_o.code_wr = 1'b1;
                ADDR_NOOP: ;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/dacrf_load_sync.sv
module dacrf_load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], load_n_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~chain_q[STAGES-1];

    // R5: one load per pin transition
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/dacrf_core.sv
module dacrf_core
    import dacrf_pkg::*;
#(
    parameter int DATA_W = DAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_code_sel_i,
    input  wr_evt_t           evt_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pin_load_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              dac_update_o
);
    localparam logic [DATA_W-1:0] CODE_ZERO = '0;
    localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};

    mode_e             state_q, state_nx;
    logic [DATA_W-1:0] buf_q, act_q;
    logic              upd_q;
    logic [DATA_W-1:0] rst_code;

    assign rst_code = rst_code_sel_i ? CODE_MID : CODE_ZERO;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            MODE_DIRECT:   if (evt_i.mode_wr &&  evt_i.mode_val) state_nx = MODE_BUFFERED;
            MODE_BUFFERED: if (evt_i.mode_wr && !evt_i.mode_val) state_nx = MODE_DIRECT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || evt_i.srst) begin
            state_q <= MODE_DIRECT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Outputs: buffer, active code, strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= rst_code;
            act_q <= rst_code;
            upd_q <= 1'b0;
        end else if (evt_i.srst) begin
            buf_q <= rst_code;
            act_q <= rst_code;
            upd_q <= 1'b1;
        end else begin
            upd_q <= 1'b0;
            if (evt_i.code_wr) begin
                buf_q <= wr_data_i;
            end
            unique case (state_q)
                MODE_DIRECT: begin
                    if (evt_i.code_wr) begin
                        act_q <= wr_data_i;
                        upd_q <= 1'b1;
                    end
                end
                MODE_BUFFERED: begin
                    if (evt_i.load_sw || pin_load_i) begin
                        act_q <= buf_q;
                        upd_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign dac_code_o   = act_q;
    assign dac_update_o = upd_q;

    // R1: reset forces the strap-selected code and a quiet strobe
    a_r1_reset_code: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == ($past(rst_code_sel_i) ? CODE_MID : CODE_ZERO)) && !dac_update_o);

    // R2: direct-mode write reaches the output one edge later
    a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_DIRECT && evt_i.code_wr && !evt_i.srst)
        |=> (dac_code_o == $past(wr_data_i)) && dac_update_o);

    // R3: buffered-mode write alone does not move the output
    a_r3_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_BUFFERED && evt_i.code_wr && !pin_load_i && !evt_i.srst)
        |=> $stable(dac_code_o) && !dac_update_o);

    // R6: soft reset lands on defaults
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.srst |=> (state_q == MODE_DIRECT) && dac_update_o
            && (dac_code_o == ($past(rst_code_sel_i) ? CODE_MID : CODE_ZERO)));

    // R9: every change of the active code is strobed
    a_r9_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(dac_code_o) |-> dac_update_o);
endmodule

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs
    import dacrf_pkg::*;
#(
    parameter int DATA_W      = DAC_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_code_sel_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_n_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              dac_update_o
);
    wr_evt_t evt;
    logic    pin_load;

    dacrf_decode u_decode (
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .ctrl_bits_i (wr_data_i[CTRL_W-1:0]),
        .evt_o       (evt)
    );

    dacrf_load_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_i (load_n_i),
        .fall_o   (pin_load)
    );

    dacrf_core #(.DATA_W(DATA_W)) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .rst_code_sel_i (rst_code_sel_i),
        .evt_i          (evt),
        .wr_data_i      (wr_data_i),
        .pin_load_i     (pin_load),
        .dac_code_o     (dac_code_o),
        .dac_update_o   (dac_update_o)
    );
endmodule

// File: tb/dac_dbuf_regs_tb.sv
module dac_dbuf_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        load_n = 1'b1;
    logic [15:0] code;
    logic        upd;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dbuf_regs u_dut (
        .clk(clk), .rst_n(rst_n), .rst_code_sel_i(sel), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .load_n_i(load_n),
        .dac_code_o(code), .dac_update_o(upd)
    );

    // {addr[36:33], data[32:17], expected code[16:1], expected strobe[0]}
    localparam logic [36:0] VEC [NVEC] = '{
        {4'h8, 16'h1234, 16'h1234, 1'b1},  // R2
        {4'h8, 16'hFFFF, 16'hFFFF, 1'b1},  // R10
        {4'h0, 16'h5555, 16'hFFFF, 1'b0},  // R8 noop
        {4'h3, 16'h0000, 16'hFFFF, 1'b0},  // R8 undefined
        {4'h5, 16'h0010, 16'hFFFF, 1'b0},  // R4 load ignored in direct
        {4'h2, 16'hFFFF, 16'hFFFF, 1'b0},  // R3 enter buffered
        {4'h8, 16'h0001, 16'hFFFF, 1'b0},  // R3 buffer only
        {4'h5, 16'hFFE0, 16'hFFFF, 1'b0},  // R4 reserved bits only
        {4'h5, 16'h0010, 16'h0001, 1'b1},  // R4 load
        {4'h8, 16'hABCD, 16'h0001, 1'b0},  // R3
        {4'h5, 16'h0015, 16'hABCD, 1'b1},  // R6 wrong key, load acts
        {4'h2, 16'h0000, 16'hABCD, 1'b0},  // R3 back to direct
        {4'h8, 16'h8001, 16'h8001, 1'b1},  // R10
        {4'h2, 16'hFFFE, 16'h8001, 1'b0},  // R3 reserved bits ignored
        {4'h8, 16'h0000, 16'h0000, 1'b1}   // R3 still direct
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hw_reset(input logic s);
        @(negedge clk);
        sel = s; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 code sel=0", code, 16'h0000);
        check("R1 strobe", {15'd0, upd}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][36:33], VEC[i][32:17]);
            check($sformatf("R2/R3/R4/R8/R10 vec%0d code", i), code, VEC[i][16:1]);
            check($sformatf("R9 vec%0d strobe", i), {15'd0, upd}, {15'd0, VEC[i][0]});
        end
        @(negedge clk);
        check("R9 strobe one cycle", {15'd0, upd}, 16'd0);

        // R1 with mid-scale strap, buffer also reset
        hw_reset(1'b1);
        check("R1 code sel=1", code, 16'h8000);
        wr(4'h2, 16'h0001);
        wr(4'h5, 16'h0010);
        check("R1 buffer reset value", code, 16'h8000);

        // R6 soft reset
        wr(4'h8, 16'h2222);
        wr(4'h5, 16'h000A);
        check("R6 soft reset code", code, 16'h8000);
        check("R6 soft reset strobe", {15'd0, upd}, 16'd1);
        wr(4'h8, 16'h3333);
        check("R6 mode back to direct", code, 16'h3333);
        sel = 1'b0;
        wr(4'h5, 16'h000A);
        check("R6 strap read at soft reset", code, 16'h0000);

        // R7 reset beats load
        wr(4'h2, 16'h0001);
        wr(4'h8, 16'h4444);
        wr(4'h5, 16'h001A);
        check("R7 reset wins", code, 16'h0000);
        wr(4'h2, 16'h0001);
        wr(4'h5, 16'h0010);
        check("R7 buffer cleared", code, 16'h0000);

        // R5 pin load in buffered mode
        wr(4'h8, 16'h5A5A);
        @(negedge clk);
        load_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 not yet loaded", code, 16'h0000);
        @(negedge clk);
        check("R5 pin load code", code, 16'h5A5A);
        check("R5 pin load strobe", {15'd0, upd}, 16'd1);
        wr(4'h8, 16'h6B6B);
        repeat (4) @(negedge clk);
        check("R5 held low no reload", code, 16'h5A5A);
        load_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 pin ignored in direct mode
        wr(4'h2, 16'h0000);
        load_n = 1'b0;
        begin
            int pulses = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (upd) pulses++;
            end
            check("R5 pin ignored direct", 16'(pulses), 16'd0);
        end
        check("R5 direct code unchanged", code, 16'h5A5A);
        load_n = 1'b1;

        // R1 mid-run hardware reset
        hw_reset(1'b0);
        check("R1 mid-run reset", code, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule